// File: doc/BRIEF.md
# Multi-Class Register Busy Tracker

This block keeps a record of which architectural registers have a write in flight in a core that runs several warps. There are three register classes. Integer and floating-point registers are private to each warp, so each warp has its own pair of 32-bit busy bitmaps. Vector registers are common to all warps, so one 32-bit vector bitmap serves every warp.

At issue time the pipeline presents a warp id and three register masks, one per class. Each mask is the union of the instruction's sources and its destination. The block answers combinationally, in the same cycle, whether any of those registers is still busy. It also reports which class caused the hit. When an instruction issues, its destination is reserved. When it commits, that destination is released. Integer register 0 is hard-wired and is never marked busy.

Top module: `regfile_busy_track`

## Requirements
- R1: Integer and floating-point busy state is separate for each warp: reserving a register for one warp never makes a query from another warp report it busy.
- R2: Vector busy state is one bitmap shared by all warps: a vector register reserved by any warp is reported busy to a query from any warp.
- R3: `chk_busy` is a combinational function of the present state and query inputs. `chk_int_hit`, `chk_fp_hit` and `chk_vec_hit` are each high exactly when the matching mask overlaps the matching busy bitmap of `chk_warp`. `chk_busy` is the OR of the three. All-zero masks never report busy.
- R4: The destination class field is encoded as 0 = none, 1 = integer, 2 = floating-point and 3 = vector. A reservation or release with class 0 changes no state.
- R5: An integer reservation of register 0 is ignored, so integer register 0 is never reported busy.
- R6: A reservation with `rsv_valid` high is visible to queries from the cycle after the clock edge. A release with `rel_valid` high clears its register from the cycle after the edge.
- R7: When a reservation and a release name the same class, warp and register in one cycle, the register is busy afterwards.
- R8: An active-low reset clears every integer and floating-point bitmap of every warp and the shared vector bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_warp | input | 2 | Warp id of the issue query |
| chk_int_mask | input | 32 | Integer registers used by the instruction |
| chk_fp_mask | input | 32 | Floating-point registers used |
| chk_vec_mask | input | 32 | Vector registers used |
| chk_busy | output | 1 | Some used register is busy |
| chk_int_hit | output | 1 | Integer overlap found |
| chk_fp_hit | output | 1 | Floating-point overlap found |
| chk_vec_hit | output | 1 | Vector overlap found |
| rsv_valid | input | 1 | Reserve a destination this cycle |
| rsv_warp | input | 2 | Warp of the reservation |
| rsv_class | input | 2 | Destination class of the reservation |
| rsv_reg | input | 5 | Destination register index |
| rel_valid | input | 1 | Release a destination this cycle |
| rel_warp | input | 2 | Warp of the release |
| rel_class | input | 2 | Destination class of the release |
| rel_reg | input | 5 | Register index to release |

## Verification
The bench targets cross-warp leakage. A design that shared the integer or floating-point bitmaps would stall one warp on another warp's writes, and a design that kept vector state per warp would let a dependent vector read through. It reserves integer register 0 and class 0 destinations, which a careless decoder would turn into a permanent stall. It also issues a release and a reservation on the same register in one cycle, where letting the release win would drop a pending write. Long pseudo-random runs of mixed reservations, releases and queries are compared against a bench-side model, followed by a reset in the middle of the run.

// File: rtl/busy_pkg.sv
package busy_pkg;
  // destination class encoding, decoded by the issue stage
  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_INT  = 2'd1,
    DST_FP   = 2'd2,
    DST_VEC  = 2'd3
  } dst_class_e;
endpackage

// File: rtl/busy_decode.sv
module busy_decode
  import busy_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 32,
  parameter int WID_W     = 2,
  parameter int RID_W     = 5
) (
  input  logic                                 valid,
  input  logic [WID_W-1:0]                     warp,
  input  logic [1:0]                           cls,
  input  logic [RID_W-1:0]                     rid,
  output logic [NUM_WARPS-1:0][NUM_REGS-1:0]   int_mask,
  output logic [NUM_WARPS-1:0][NUM_REGS-1:0]   fp_mask,
  output logic [NUM_REGS-1:0]                  vec_mask
);
  // one bit set at position idx
  function automatic logic [NUM_REGS-1:0] reg_bit(input logic [RID_W-1:0] idx);
    logic [NUM_REGS-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  // integer register 0 is hard-wired and never tracked
  function automatic logic int_trackable(input logic [RID_W-1:0] idx);
    return idx != '0;
  endfunction

  logic [NUM_REGS-1:0] sel_bit;
  logic                is_int, is_fp, is_vec;

  assign sel_bit = reg_bit(rid);
  assign is_int  = valid && (dst_class_e'(cls) == DST_INT) && int_trackable(rid);
  assign is_fp   = valid && (dst_class_e'(cls) == DST_FP);
  assign is_vec  = valid && (dst_class_e'(cls) == DST_VEC);

  assign vec_mask = is_vec ? sel_bit : '0;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic hit_warp;
    assign hit_warp    = (warp == WID_W'(w));
    assign int_mask[w] = (is_int && hit_warp) ? sel_bit : '0;
    assign fp_mask[w]  = (is_fp  && hit_warp) ? sel_bit : '0;
  end
endmodule

// File: rtl/busy_bank.sv
module busy_bank #(
  parameter int NUM_REGS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] set_mask,
  input  logic [NUM_REGS-1:0] clr_mask,
  output logic [NUM_REGS-1:0] busy
);
  // release first, then reservation: a collision leaves the bit busy
  function automatic logic [NUM_REGS-1:0] next_busy(
    input logic [NUM_REGS-1:0] cur,
    input logic [NUM_REGS-1:0] setm,
    input logic [NUM_REGS-1:0] clrm
  );
    return (cur & ~clrm) | setm;
  endfunction

  logic [NUM_REGS-1:0] busy_d;
  logic [NUM_REGS-1:0] clr_only;
  logic [NUM_REGS-1:0] touched;

  assign busy_d   = next_busy(busy, set_mask, clr_mask);
  assign clr_only = clr_mask & ~set_mask;
  assign touched  = set_mask | clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= '0;
    else        busy <= busy_d;
  end

  // R6 R7
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((busy & $past(set_mask)) == $past(set_mask)));

  // R6
  clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_only != '0) |=> ((busy & $past(clr_only)) == '0));

  // R4
  untouched_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((busy ^ $past(busy)) & ~$past(touched)) == '0));
endmodule

// File: rtl/busy_query.sv
module busy_query #(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 32,
  parameter int WID_W     = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_WARPS-1:0][NUM_REGS-1:0] int_busy,
  input  logic [NUM_WARPS-1:0][NUM_REGS-1:0] fp_busy,
  input  logic [NUM_REGS-1:0]                vec_busy,
  input  logic [WID_W-1:0]                   warp,
  input  logic [NUM_REGS-1:0]                int_use,
  input  logic [NUM_REGS-1:0]                fp_use,
  input  logic [NUM_REGS-1:0]                vec_use,
  output logic                               int_hit,
  output logic                               fp_hit,
  output logic                               vec_hit,
  output logic                               any_hit
);
  function automatic logic overlaps(
    input logic [NUM_REGS-1:0] a,
    input logic [NUM_REGS-1:0] b
  );
    return |(a & b);
  endfunction

  logic [NUM_REGS-1:0] int_sel, fp_sel;

  always_comb begin
    int_sel = '0;
    fp_sel  = '0;
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (warp == WID_W'(w)) begin
        int_sel = int_busy[w];
        fp_sel  = fp_busy[w];
      end
    end
  end

  assign int_hit = overlaps(int_sel, int_use);
  assign fp_hit  = overlaps(fp_sel, fp_use);
  assign vec_hit = overlaps(vec_busy, vec_use);
  assign any_hit = int_hit | fp_hit | vec_hit;

  // R3
  empty_query_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_use == '0) && (fp_use == '0) && (vec_use == '0)) |-> !any_hit);
endmodule

// File: rtl/regfile_busy_track.sv
module regfile_busy_track
  import busy_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 32,
  parameter int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  parameter int RID_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WID_W-1:0]    chk_warp,
  input  logic [NUM_REGS-1:0] chk_int_mask,
  input  logic [NUM_REGS-1:0] chk_fp_mask,
  input  logic [NUM_REGS-1:0] chk_vec_mask,
  output logic                chk_busy,
  output logic                chk_int_hit,
  output logic                chk_fp_hit,
  output logic                chk_vec_hit,
  input  logic                rsv_valid,
  input  logic [WID_W-1:0]    rsv_warp,
  input  logic [1:0]          rsv_class,
  input  logic [RID_W-1:0]    rsv_reg,
  input  logic                rel_valid,
  input  logic [WID_W-1:0]    rel_warp,
  input  logic [1:0]          rel_class,
  input  logic [RID_W-1:0]    rel_reg
);
  logic [NUM_WARPS-1:0][NUM_REGS-1:0] set_int, set_fp, clr_int, clr_fp;
  logic [NUM_WARPS-1:0][NUM_REGS-1:0] int_busy, fp_busy;
  logic [NUM_REGS-1:0]                set_vec, clr_vec, vec_busy;

  busy_decode #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS),
                .WID_W(WID_W), .RID_W(RID_W)) rsv_dec_i (
    .valid(rsv_valid), .warp(rsv_warp), .cls(rsv_class), .rid(rsv_reg),
    .int_mask(set_int), .fp_mask(set_fp), .vec_mask(set_vec)
  );

  busy_decode #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS),
                .WID_W(WID_W), .RID_W(RID_W)) rel_dec_i (
    .valid(rel_valid), .warp(rel_warp), .cls(rel_class), .rid(rel_reg),
    .int_mask(clr_int), .fp_mask(clr_fp), .vec_mask(clr_vec)
  );

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    busy_bank #(.NUM_REGS(NUM_REGS)) int_bank_i (
      .clk(clk), .rst_n(rst_n), .set_mask(set_int[w]),
      .clr_mask(clr_int[w]), .busy(int_busy[w])
    );
    busy_bank #(.NUM_REGS(NUM_REGS)) fp_bank_i (
      .clk(clk), .rst_n(rst_n), .set_mask(set_fp[w]),
      .clr_mask(clr_fp[w]), .busy(fp_busy[w])
    );

    // R5
    int_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> !int_busy[w][0]);
  end

  busy_bank #(.NUM_REGS(NUM_REGS)) vec_bank_i (
    .clk(clk), .rst_n(rst_n), .set_mask(set_vec),
    .clr_mask(clr_vec), .busy(vec_busy)
  );

  busy_query #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS),
               .WID_W(WID_W)) query_i (
    .clk(clk), .rst_n(rst_n),
    .int_busy(int_busy), .fp_busy(fp_busy), .vec_busy(vec_busy),
    .warp(chk_warp), .int_use(chk_int_mask), .fp_use(chk_fp_mask),
    .vec_use(chk_vec_mask),
    .int_hit(chk_int_hit), .fp_hit(chk_fp_hit), .vec_hit(chk_vec_hit),
    .any_hit(chk_busy)
  );

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> ((int_busy == '0) && (fp_busy == '0) && (vec_busy == '0)));

  // R4
  none_class_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && (rsv_class == 2'd0) && !rel_valid) |=>
      (int_busy == $past(int_busy)) && (fp_busy == $past(fp_busy)) &&
      (vec_busy == $past(vec_busy)));
endmodule

// File: tb/regfile_busy_track_tb_top.sv
module regfile_busy_track_tb_top;
  localparam int NW = 4;
  localparam int NR = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  chk_warp = '0;
  logic [31:0] chk_int_mask = '0, chk_fp_mask = '0, chk_vec_mask = '0;
  logic chk_busy, chk_int_hit, chk_fp_hit, chk_vec_hit;
  logic rsv_valid = 1'b0, rel_valid = 1'b0;
  logic [1:0] rsv_warp = '0, rsv_class = '0, rel_warp = '0, rel_class = '0;
  logic [4:0] rsv_reg = '0, rel_reg = '0;

  always #10 clk = ~clk;  // 50 MHz

  regfile_busy_track dut_i (
    .clk(clk), .rst_n(rst_n), .chk_warp(chk_warp),
    .chk_int_mask(chk_int_mask), .chk_fp_mask(chk_fp_mask),
    .chk_vec_mask(chk_vec_mask), .chk_busy(chk_busy),
    .chk_int_hit(chk_int_hit), .chk_fp_hit(chk_fp_hit),
    .chk_vec_hit(chk_vec_hit), .rsv_valid(rsv_valid), .rsv_warp(rsv_warp),
    .rsv_class(rsv_class), .rsv_reg(rsv_reg), .rel_valid(rel_valid),
    .rel_warp(rel_warp), .rel_class(rel_class), .rel_reg(rel_reg)
  );

  // reference state
  logic [31:0] m_int [NW];
  logic [31:0] m_fp  [NW];
  logic [31:0] m_vec;

  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t exp_q[$];
  event  chk_ev;
  int n_checks = 0, n_fails = 0;
  bit done = 0;

  task automatic model_clear();
    for (int w = 0; w < NW; w++) begin m_int[w] = '0; m_fp[w] = '0; end
    m_vec = '0;
  endtask

  // bit-by-bit overlap, written apart from the design
  function automatic logic any_common(input logic [31:0] a, input logic [31:0] b);
    for (int i = 0; i < NR; i++) if (a[i] === 1'b1 && b[i] === 1'b1) return 1'b1;
    return 1'b0;
  endfunction

  // driver: apply a query and push the expected {busy,int,fp,vec}
  task automatic query(input int w, input logic [31:0] im, input logic [31:0] fm,
                       input logic [31:0] vm, input string tag);
    item_t it;
    logic ih, fh, vh;
    chk_warp = 2'(w); chk_int_mask = im; chk_fp_mask = fm; chk_vec_mask = vm;
    ih = any_common(m_int[w], im);
    fh = any_common(m_fp[w], fm);
    vh = any_common(m_vec, vm);
    it.exp = {ih | fh | vh, ih, fh, vh};
    it.tag = tag;
    exp_q.push_back(it);
    -> chk_ev;
    #3;
  endtask

  // monitor
  initial begin
    forever begin
      @(chk_ev);
      #1;
      if (exp_q.size() != 0) begin
        item_t it;
        logic [3:0] got;
        it = exp_q.pop_front();
        got = {chk_busy, chk_int_hit, chk_fp_hit, chk_vec_hit};
        n_checks++;
        if (got !== it.exp) begin
          n_fails++;
          $display("FAIL %s: got %b expected %b", it.tag, got, it.exp);
        end
      end
    end
  end

  // one clock with optional reservation/release; called just after a negedge
  task automatic op(input bit rv, input int rw, input int rc, input int rr,
                    input bit lv, input int lw, input int lc, input int lr);
    rsv_valid = rv; rsv_warp = 2'(rw); rsv_class = 2'(rc); rsv_reg = 5'(rr);
    rel_valid = lv; rel_warp = 2'(lw); rel_class = 2'(lc); rel_reg = 5'(lr);
    @(posedge clk);
    #1;
    if (lv) begin
      if (lc == 1) m_int[lw][lr] = 1'b0;
      else if (lc == 2) m_fp[lw][lr] = 1'b0;
      else if (lc == 3) m_vec[lr] = 1'b0;
    end
    if (rv) begin
      if (rc == 1 && rr != 0) m_int[rw][rr] = 1'b1;
      else if (rc == 2) m_fp[rw][rr] = 1'b1;
      else if (rc == 3) m_vec[rr] = 1'b1;
    end
    @(negedge clk);
    rsv_valid = 1'b0; rel_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    model_clear();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    for (int w = 0; w < NW; w++) query(w, '1, '1, '1, "R8 reset state all clear");

    // R6 reservation visible next cycle; R1 other warp unaffected
    op(1, 0, 1, 5, 0, 0, 0, 0);
    query(0, 32'h20, '0, '0, "R6 int r5 warp0 busy");
    query(1, 32'h20, '0, '0, "R1 int r5 warp1 free");
    query(0, 32'hFFFF_FFDF, '0, '0, "R3 non-overlapping int mask");

    op(1, 1, 2, 5, 0, 0, 0, 0);
    query(1, '0, 32'h20, '0, "R1 fp r5 warp1 busy");
    query(0, '0, 32'h20, '0, "R1 fp r5 warp0 free");

    // R2 shared vector
    op(1, 2, 3, 7, 0, 0, 0, 0);
    for (int w = 0; w < NW; w++) query(w, '0, '0, 32'h80, "R2 vec r7 seen by all warps");

    // R5 integer register 0
    op(1, 2, 1, 0, 0, 0, 0, 0);
    query(2, '1, '0, '0, "R5 int r0 never busy");

    // R4 class 0
    op(1, 3, 0, 9, 0, 0, 0, 0);
    query(3, '1, '1, 32'hFFFF_FF7F, "R4 class none reserves nothing");
    op(0, 0, 0, 0, 1, 2, 0, 7);
    query(2, '0, '0, 32'h80, "R4 class none releases nothing");

    // R6 release
    op(0, 0, 0, 0, 1, 0, 1, 5);
    query(0, 32'h20, '0, '0, "R6 int r5 released");

    // R7 collision
    op(1, 1, 2, 5, 1, 1, 2, 5);
    query(1, '0, 32'h20, '0, "R7 busy fp reserve+release stays busy");
    op(1, 0, 1, 6, 1, 0, 1, 6);
    query(0, 32'h40, '0, '0, "R7 idle int reserve+release becomes busy");
    op(1, 3, 3, 7, 1, 3, 3, 7);
    query(1, '0, '0, 32'h80, "R7 vec reserve+release stays busy");

    // R3 mixed classes in one query
    query(1, 32'h40, 32'h20, '0, "R3 fp hit only for warp1");
    query(0, 32'h40, 32'h20, 32'h80, "R3 int and vec hit warp0");

    // pseudo-random run, R1 R2 R3 R6 R7
    for (int k = 0; k < 600; k++) begin
      int sel;
      sel = $urandom_range(0, 3);
      op($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 3),
         $urandom_range(0, 7),
         sel != 0, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 7));
      query($urandom_range(0, 3), 32'(1) << $urandom_range(0, 7),
            32'(1) << $urandom_range(0, 7), 32'(1) << $urandom_range(0, 7),
            "R3 R6 R7 random single-bit query");
      query($urandom_range(0, 3), $urandom, $urandom, $urandom,
            "R1 R2 R3 random wide query");
    end

    // R8 reset in the middle of a run
    op(1, 1, 1, 3, 0, 0, 0, 0);
    do_reset();
    for (int w = 0; w < NW; w++) query(w, '1, '1, '1, "R8 mid-run reset clears all");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end
endmodule